// File: doc/BRIEF.md
# Inter-Driver Level-Sequence Mismatch Monitor

In a panel built from several column drivers, one driver (the master) produces the frame pulse and a two-bit row-level sequence. Every other driver (a slave) runs its own copy of that sequence. This block sits in each driver. A slave compares the master's level bits with its own copy once per half frame, on the low-to-high transition of the active-low frame pulse. If the two disagree, the slave pulls a shared open-drain refresh line low. Every driver watches that line. Any driver that sees it low raises an internal timing reset, which stops its oscillator and restarts its timing generators. The palette storage is not part of that reset.

The frame pulse, both level buses and the shared line arrive asynchronously. Each passes through two flip-flops before use. After a refresh the display stays blank. It comes back only after eight frame-pulse rises (four frames of two half-frame pulses) have been counted once the line is high again. The first frame-pulse rise after any restart only re-aligns the slave and is never compared.

The controller has four states. ARM waits for the first frame rise. WATCH compares on each rise. PULL drives the line for a fixed count. HOLD waits for the line to read high. The transitions are:
- system reset → ARM
- ARM → WATCH on a frame rise
- ARM → HOLD, or WATCH → HOLD, when the line reads low
- WATCH → PULL on a slave mismatch at a rise
- PULL → HOLD after the pull count
- HOLD → ARM when the line reads high

Top module: `lvl_sync_watch`

## Requirements
- R1: After system reset, `refresh_pull` and `timing_rst` are 0 and `disp_off` is 1.
- R2: In WATCH, a slave (`is_master`=0) asserts `refresh_pull` when, at a 0→1 transition of `frm_n_in`, `mst_lvl` differs from `own_lvl` in bit 0 (line 1) or bit 1 (line 2). The pull is visible 3 clock cycles after the transition reaches the input. Equal levels at the transition give no pull.
- R3: A level difference while `frm_n_in` stays high, or at a 1→0 transition, causes no pull.
- R4: With `is_master`=1, no level difference ever asserts `refresh_pull`.
- R5: `refresh_pull` stays high for exactly PULL_CYC (default 4) consecutive cycles and is then released.
- R6: `timing_rst` is high exactly while the shared line `refresh_n_in`, delayed by 2 cycles, is low. This holds whether this driver or another one pulls the line. A pull from another driver never raises `refresh_pull` here.
- R7: After reset, or after the line returns high, the first frame rise is not compared, even with differing levels. The second frame rise is compared.
- R8: `disp_off` is 1 from reset and while `timing_rst` is high. It falls 3 cycles after the 8th frame rise counted after `timing_rst` drops.
- R9: Asserting the system reset during a pull releases `refresh_pull` at once. The monitor then returns to ARM.
- R10: Frame rises that arrive while the line reads low are neither compared nor counted toward R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| is_master | input | 1 | Strap: 1 for the master driver, 0 for a slave |
| frm_n_in | input | 1 | Frame pulse, active low, asynchronous |
| mst_lvl | input | LVL_W | Master's row-level bits; bit 0 is line 1, bit 1 is line 2 |
| own_lvl | input | LVL_W | This driver's own row-level bits, same bit order |
| refresh_n_in | input | 1 | Shared wired-OR refresh line as sampled, active low |
| refresh_pull | output | 1 | Enables the open-drain pull-down on the refresh line |
| timing_rst | output | 1 | Internal timing reset to the oscillator and timing generators |
| disp_off | output | 1 | Display blank request |

## Verification
A frame rise driven between clock edges reaches the controller through two synchroniser flops and the edge register. The pull therefore appears at the third falling clock edge after the drive. The line's effect on `timing_rst` arrives two falling edges after the line changes, so a self-issued pull shows `timing_rst` on edges 5 to 8 after the frame rise. Each directed task counts falling edges from its own stimulus and samples every output at exactly those offsets. It checks both the first and the last cycle of each window. The "no pull" cases count pull cycles over a window longer than the whole latency chain.

// File: rtl/lvl_watch_pkg.sv
`timescale 1ns/1ps
package lvl_watch_pkg;
    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_WATCH = 2'd1,
        ST_PULL  = 2'd2,
        ST_HOLD  = 2'd3
    } watch_st_e;
endpackage

// File: rtl/lvl_sync_bank.sv
`timescale 1ns/1ps
module lvl_sync_bank #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic stage1;
        logic stage2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1 <= RST_VAL[b];
                stage2 <= RST_VAL[b];
            end else begin
                stage1 <= d[b];
                stage2 <= stage1;
            end
        end
        assign q[b] = stage2;
    end
endmodule

// File: rtl/lvl_rise_det.sv
`timescale 1ns/1ps
module lvl_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b1;
        else        sig_q <= sig;
    end
    assign rise = sig & ~sig_q;
endmodule

// File: rtl/lvl_watch_fsm.sv
`timescale 1ns/1ps
module lvl_watch_fsm
    import lvl_watch_pkg::*;
#(
    parameter int LVL_W    = 2,
    parameter int PULL_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_rise,
    input  logic             line_low,
    input  logic             is_master,
    input  logic [LVL_W-1:0] mst_s,
    input  logic [LVL_W-1:0] own_s,
    output logic             pull_en
);
    localparam int CW = $clog2(PULL_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PULL_CYC - 1);

    watch_st_e st, st_nx;
    logic [CW-1:0] pull_cnt;
    logic lvl_diff;

    assign lvl_diff = (mst_s ^ own_s) != '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_ARM;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pull_cnt <= '0;
        else if (st == ST_PULL)  pull_cnt <= pull_cnt + 1'b1;
        else                     pull_cnt <= '0;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_ARM: begin
                if (line_low)      st_nx = ST_HOLD;
                else if (frm_rise) st_nx = ST_WATCH;
            end
            ST_WATCH: begin
                if (line_low)
                    st_nx = ST_HOLD;
                else if (frm_rise && !is_master && lvl_diff)
                    st_nx = ST_PULL;
            end
            ST_PULL: begin
                if (pull_cnt == LAST) st_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (!line_low) st_nx = ST_ARM;
            end
        endcase
    end

    always_comb begin
        pull_en = (st == ST_PULL);
    end
endmodule

// File: rtl/lvl_blank_ctr.sv
`timescale 1ns/1ps
module lvl_blank_ctr #(
    parameter int BLANK_EDGES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_rise,
    input  logic hold,
    output logic disp_off
);
    localparam int BW = $clog2(BLANK_EDGES + 1);
    localparam logic [BW-1:0] TOP = BW'(BLANK_EDGES);

    logic [BW-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         seen <= '0;
        else if (hold)                      seen <= '0;
        else if (frm_rise && seen != TOP)   seen <= seen + 1'b1;
    end

    assign disp_off = (seen != TOP);
endmodule

// File: rtl/lvl_sync_watch.sv
`timescale 1ns/1ps
module lvl_sync_watch #(
    parameter int LVL_W            = 2,
    parameter int PULL_CYC         = 4,
    parameter int BLANK_FRAMES     = 4,
    parameter int PULSES_PER_FRAME = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             frm_n_in,
    input  logic [LVL_W-1:0] mst_lvl,
    input  logic [LVL_W-1:0] own_lvl,
    input  logic             refresh_n_in,
    output logic             refresh_pull,
    output logic             timing_rst,
    output logic             disp_off
);
    localparam int BLANK_EDGES = BLANK_FRAMES * PULSES_PER_FRAME;

    logic [1:0]       ctl_s;
    logic [LVL_W-1:0] mst_s;
    logic [LVL_W-1:0] own_s;
    logic             frm_rise;
    logic             line_low;

    // frame pulse and shared line idle high
    lvl_sync_bank #(.W(2), .RST_VAL(2'b11)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({refresh_n_in, frm_n_in}), .q(ctl_s)
    );

    lvl_sync_bank #(.W(LVL_W), .RST_VAL('0)) u_sync_mst (
        .clk(clk), .rst_n(rst_n), .d(mst_lvl), .q(mst_s)
    );

    lvl_sync_bank #(.W(LVL_W), .RST_VAL('0)) u_sync_own (
        .clk(clk), .rst_n(rst_n), .d(own_lvl), .q(own_s)
    );

    lvl_rise_det u_rise (
        .clk(clk), .rst_n(rst_n), .sig(ctl_s[0]), .rise(frm_rise)
    );

    assign line_low = ~ctl_s[1];

    lvl_watch_fsm #(.LVL_W(LVL_W), .PULL_CYC(PULL_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .frm_rise(frm_rise), .line_low(line_low), .is_master(is_master),
        .mst_s(mst_s), .own_s(own_s), .pull_en(refresh_pull)
    );

    lvl_blank_ctr #(.BLANK_EDGES(BLANK_EDGES)) u_blank (
        .clk(clk), .rst_n(rst_n),
        .frm_rise(frm_rise), .hold(line_low), .disp_off(disp_off)
    );

    assign timing_rst = line_low;
endmodule

// File: rtl/lvl_sync_watch_chk.sv
`timescale 1ns/1ps
module lvl_sync_watch_chk #(
    parameter int LVL_W    = 2,
    parameter int PULL_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             is_master,
    input logic             frm_n_in,
    input logic [LVL_W-1:0] mst_lvl,
    input logic [LVL_W-1:0] own_lvl,
    input logic             refresh_n_in,
    input logic             refresh_pull,
    input logic             timing_rst,
    input logic             disp_off
);
    localparam int RW = $clog2(PULL_CYC + 1) + 1;

    logic [RW-1:0] run;
    logic [1:0]    age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run <= '0;
        else if (refresh_pull) run <= run + 1'b1;
        else                   run <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    // R5
    pull_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pull |-> run < RW'(PULL_CYC));

    // R5
    pull_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refresh_pull) |-> run == RW'(PULL_CYC));

    // R4
    master_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_pull) |-> !$past(is_master));

    // R2
    pull_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_pull) |-> ($past(mst_lvl, 3) != $past(own_lvl, 3)));

    // R3
    pull_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_pull) |-> ($past(frm_n_in, 3) && !$past(frm_n_in, 4)));

    // R6
    line_to_trst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (timing_rst == !$past(refresh_n_in, 2)));

    // R8
    trst_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timing_rst |=> disp_off);
endmodule

bind lvl_sync_watch lvl_sync_watch_chk #(.LVL_W(LVL_W), .PULL_CYC(PULL_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .frm_n_in(frm_n_in),
    .mst_lvl(mst_lvl), .own_lvl(own_lvl), .refresh_n_in(refresh_n_in),
    .refresh_pull(refresh_pull), .timing_rst(timing_rst), .disp_off(disp_off)
);

// File: tb/test_lvl_sync_watch.sv
`timescale 1ns/1ps
module test_lvl_sync_watch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b0;
    logic       frm_n = 1'b1;
    logic [1:0] mst_lvl = 2'b00;
    logic [1:0] own_lvl = 2'b00;
    logic       ext_pull = 1'b0;
    logic       refresh_n;
    logic       refresh_pull;
    logic       timing_rst;
    logic       disp_off;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    assign refresh_n = ~(refresh_pull | ext_pull);

    lvl_sync_watch i_lvl_sync_watch (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .frm_n_in(frm_n),
        .mst_lvl(mst_lvl), .own_lvl(own_lvl), .refresh_n_in(refresh_n),
        .refresh_pull(refresh_pull), .timing_rst(timing_rst), .disp_off(disp_off)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic frame_rise(input logic [1:0] m, input logic [1:0] o);
        @(negedge clk);
        mst_lvl = m;
        own_lvl = o;
        frm_n   = 1'b0;
        repeat (3) @(negedge clk);
        frm_n = 1'b1;
    endtask

    task automatic chk_quiet(input int n, input string tag);
        int hits;
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (refresh_pull) hits++;
        end
        chk(tag, hits, 0);
    endtask

    task automatic chk_refresh_seq(input string tag);
        for (int i = 1; i <= 9; i++) begin
            @(negedge clk);
            chk({tag, " R2 R5 pull"}, int'(refresh_pull), int'(i >= 3 && i <= 6));
            chk({tag, " R6 trst"}, int'(timing_rst), int'(i >= 5 && i <= 8));
            if (i == 6) chk({tag, " R8 blank"}, int'(disp_off), 1);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pull", int'(refresh_pull), 0);
        chk("R1 trst", int'(timing_rst), 0);
        chk("R1 blank", int'(disp_off), 1);
    endtask

    task automatic t_first_and_match;
        frame_rise(2'b01, 2'b00);
        chk_quiet(10, "R7 first rise after reset skipped");
        frame_rise(2'b00, 2'b00);
        chk_quiet(10, "R2 equal levels no pull");
    endtask

    task automatic t_level_only;
        @(negedge clk);
        mst_lvl = 2'b11;
        chk_quiet(8, "R3 steady high no pull");
        @(negedge clk);
        frm_n = 1'b0;
        chk_quiet(8, "R3 falling edge no pull");
        @(negedge clk);
        mst_lvl = 2'b00;
        repeat (2) @(negedge clk);
        frm_n = 1'b1;
        chk_quiet(8, "R3 matched rise no pull");
    endtask

    task automatic t_mismatch;
        frame_rise(2'b01, 2'b00);
        chk_refresh_seq("line1 diff");
        frame_rise(2'b10, 2'b00);
        chk_quiet(10, "R7 first rise after refresh skipped");
        frame_rise(2'b10, 2'b00);
        chk_refresh_seq("line2 diff");
        frame_rise(2'b11, 2'b11);
        chk_quiet(8, "R2 rearm equal");
    endtask

    task automatic t_master;
        @(negedge clk);
        is_master = 1'b1;
        frame_rise(2'b11, 2'b00);
        chk_quiet(10, "R4 master diff both");
        frame_rise(2'b01, 2'b10);
        chk_quiet(10, "R4 master diff swap");
        @(negedge clk);
        is_master = 1'b0;
    endtask

    task automatic t_ext_and_blank;
        @(negedge clk);
        ext_pull = 1'b1;
        @(negedge clk);
        chk("R6 ext trst lat1", int'(timing_rst), 0);
        @(negedge clk);
        chk("R6 ext trst lat2", int'(timing_rst), 1);
        frame_rise(2'b01, 2'b00);
        chk_quiet(8, "R10 rise while line low");
        chk("R6 ext no self pull", int'(refresh_pull), 0);
        chk("R8 blank during ext", int'(disp_off), 1);
        @(negedge clk);
        ext_pull = 1'b0;
        @(negedge clk);
        chk("R6 release lat1", int'(timing_rst), 1);
        @(negedge clk);
        chk("R6 release lat2", int'(timing_rst), 0);
        frame_rise(2'b01, 2'b00);
        chk_quiet(6, "R7 first rise after ext skipped");
        for (int k = 0; k < 6; k++) begin
            frame_rise(2'b00, 2'b00);
            repeat (4) @(negedge clk);
        end
        chk("R8 R10 blank after 7 rises", int'(disp_off), 1);
        frame_rise(2'b00, 2'b00);
        repeat (2) @(negedge clk);
        chk("R8 blank 2 after 8th", int'(disp_off), 1);
        @(negedge clk);
        chk("R8 shown 3 after 8th", int'(disp_off), 0);
    endtask

    task automatic t_sysreset;
        frame_rise(2'b01, 2'b00);
        repeat (4) @(negedge clk);
        chk("R9 pull before reset", int'(refresh_pull), 1);
        rst_n = 1'b0;
        #1;
        chk("R9 pull dropped", int'(refresh_pull), 0);
        chk("R9 trst low", int'(timing_rst), 0);
        chk("R9 blank", int'(disp_off), 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        frame_rise(2'b01, 2'b00);
        chk_quiet(10, "R9 R7 first rise after reset skipped");
        frame_rise(2'b01, 2'b00);
        chk_refresh_seq("after reset");
    endtask

    initial begin
        t_reset();
        t_first_and_match();
        t_level_only();
        t_mismatch();
        t_master();
        t_ext_and_blank();
        t_sysreset();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule